// File: doc/BRIEF.md
# Fractional Outstanding-Transaction Regulator

This block sits in front of a slave port on an AXI-style interconnect. It limits how many read and write transactions a master may have in flight at once. Each direction has its own limit, made of an integer part and an 8-bit fractional part. When the fractional part is nonzero, the limit holds as a long-run mean rather than as a hard cap. The block stalls a new address handshake by pulling down both the ready returned to the master and the valid passed downstream. It releases the stall once issuing would no longer break the limit.

Only requests in the regulated class are counted and stalled. A request is in that class when its QoS value is zero and it carries data. Requests with nonzero QoS, and dataless requests such as cache maintenance, barriers and DVM, pass straight through. The downstream fabric reports when a completion belongs to a regulated-class request, using a class flag sent with the last read beat or the write response.

For each direction the block keeps an outstanding counter and a signed credit accumulator. The accumulator has 8 fractional bits. On every cycle it gains the programmed limit and loses the current count. It saturates at +1.0, which is one transaction, and at a deep negative floor.

Top module: `ot_regulator`

## Requirements
- R1: After reset both outstanding counts and both credit accumulators are zero. With regulation enabled and an integer part of at least 1, a regulated request is accepted at once.
- R2: A regulated read is counted from its address handshake. It stays counted until a read beat is accepted with `r_last`=1 and `r_regcls`=1. A beat with `r_last`=0, or with `r_regcls`=0, does not release it.
- R3: When the fractional part is zero, a regulated request is accepted only while the count is below the integer part. The count therefore never exceeds the integer part.
- R4: When the fractional part is nonzero, a request is also accepted when the count equals the integer part, provided the accumulator is non-negative. The count never exceeds the integer part plus one.
- R5: On every cycle the accumulator adds (integer + fraction/256 − count), using the count held before that edge. The sum saturates at +1.0. Worked case: integer 0 and fraction 0x80, starting from full credit. A request is accepted at edge P0 and completes at edge P50. The block then blocks the next request through the state after edge P97 and allows it after edge P98.
- R6: A request with a nonzero `*_qos` is never stalled and is not counted.
- R7: A request with `*_nodata`=1 is never stalled and is not counted.
- R8: When `reg_en`=0, every request passes. Regulated requests are still counted, so enabling regulation later accounts for transactions already in flight.
- R9: While a regulated request is held back, the valid sent downstream and the ready sent to the master are both low.
- R10: The read and write directions have separate limits and separate state. A write completes when a write response is accepted with `b_regcls`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Regulation enable |
| rd_lim_int | input | INT_W | Read limit, integer part |
| rd_lim_frac | input | FRAC_W | Read limit, fractional part (units of 1/256) |
| wr_lim_int | input | INT_W | Write limit, integer part |
| wr_lim_frac | input | FRAC_W | Write limit, fractional part |
| ar_valid | input | 1 | Read address valid from the master |
| ar_ready | output | 1 | Read address ready to the master |
| ar_qos | input | QOS_W | Read request QoS |
| ar_nodata | input | 1 | Read request carries no data |
| ar_valid_dn | output | 1 | Read address valid to downstream |
| ar_ready_dn | input | 1 | Read address ready from downstream |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_last | input | 1 | Last read beat |
| r_regcls | input | 1 | Read completion belongs to the regulated class |
| aw_valid | input | 1 | Write address valid from the master |
| aw_ready | output | 1 | Write address ready to the master |
| aw_qos | input | QOS_W | Write request QoS |
| aw_nodata | input | 1 | Write request carries no data |
| aw_valid_dn | output | 1 | Write address valid to downstream |
| aw_ready_dn | input | 1 | Write address ready from downstream |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_regcls | input | 1 | Write completion belongs to the regulated class |

## Verification
The checker watches several properties on every cycle: the hard caps on the count at each accepted handshake, the increment of the count, the pass-through of unregulated and disabled traffic, and the joint stall of valid and ready. The mean-rate behaviour cannot be seen cycle by cycle, because it depends on history. Only the bench's directed scenarios show it: the worked-case release at exactly edge P98, the credit ceiling after long idle, and the recovery of the count after completions.

// File: rtl/ot_reg_pkg.sv
package ot_reg_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_RD  = 0;
  localparam int CH_WR  = 1;
endpackage

// File: rtl/ot_track_cnt.sv
module ot_track_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (inc && !dec && cnt_q != CNT_MAX) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end else if (dec && !inc && cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ot_credit_acc.sv
module ot_credit_acc #(
  parameter int CNT_W  = 6,
  parameter int INT_W  = 4,
  parameter int FRAC_W = 8,
  parameter int ACC_W  = CNT_W + FRAC_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  lim_int,
  input  logic [FRAC_W-1:0] lim_frac,
  input  logic [CNT_W-1:0]  cnt,
  output logic              credit_ok
);
  localparam int SW = ACC_W + 1;
  localparam logic signed [SW-1:0] CEIL_V  = SW'(2 ** FRAC_W);
  localparam logic signed [SW-1:0] FLOOR_V = SW'(-(2 ** (ACC_W - 2)));

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [SW-1:0]    lim_fx, use_fx, sum;

  always_comb begin
    lim_fx = SW'($signed({1'b0, lim_int, lim_frac}));
    use_fx = SW'($signed({1'b0, cnt, {FRAC_W{1'b0}}}));
    sum    = SW'(acc_q) + lim_fx - use_fx;
    if (sum > CEIL_V)       acc_d = CEIL_V[ACC_W-1:0];
    else if (sum < FLOOR_V) acc_d = FLOOR_V[ACC_W-1:0];
    else                    acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign credit_ok = ~acc_q[ACC_W-1];
endmodule

// File: rtl/ot_chan_gate.sv
module ot_chan_gate #(
  parameter int CNT_W  = 6,
  parameter int INT_W  = 4,
  parameter int FRAC_W = 8,
  parameter int QOS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [INT_W-1:0]  lim_int,
  input  logic [FRAC_W-1:0] lim_frac,
  input  logic              a_valid,
  input  logic [QOS_W-1:0]  a_qos,
  input  logic              a_nodata,
  input  logic              a_ready_dn,
  output logic              a_valid_dn,
  output logic              a_ready_up,
  input  logic              done,
  output logic [CNT_W-1:0]  cnt
);
  logic regulated, permit, hold, credit_ok, inc;
  logic [CNT_W-1:0] lim_c;

  assign lim_c     = CNT_W'(lim_int);
  assign regulated = (a_qos == '0) && !a_nodata;
  assign permit    = (cnt < lim_c) ||
                     ((cnt == lim_c) && (lim_frac != '0) && credit_ok);
  assign hold      = en && regulated && !permit;
  assign a_valid_dn = a_valid && !hold;
  assign a_ready_up = a_ready_dn && !hold;
  assign inc       = a_valid && a_ready_up && regulated;

  ot_track_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .dec(done), .cnt(cnt)
  );

  ot_credit_acc #(.CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .lim_int(lim_int), .lim_frac(lim_frac),
    .cnt(cnt), .credit_ok(credit_ok)
  );
endmodule

// File: rtl/ot_regulator.sv
module ot_regulator
  import ot_reg_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int INT_W  = 4,
  parameter int FRAC_W = 8,
  parameter int QOS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic [INT_W-1:0]  rd_lim_int,
  input  logic [FRAC_W-1:0] rd_lim_frac,
  input  logic [INT_W-1:0]  wr_lim_int,
  input  logic [FRAC_W-1:0] wr_lim_frac,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [QOS_W-1:0]  ar_qos,
  input  logic              ar_nodata,
  output logic              ar_valid_dn,
  input  logic              ar_ready_dn,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic              r_last,
  input  logic              r_regcls,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [QOS_W-1:0]  aw_qos,
  input  logic              aw_nodata,
  output logic              aw_valid_dn,
  input  logic              aw_ready_dn,
  input  logic              b_valid,
  input  logic              b_ready,
  input  logic              b_regcls
);
  logic [NUM_CH-1:0] ch_valid, ch_nodata, ch_rdy_dn, ch_valid_dn, ch_rdy_up, ch_done;
  logic [INT_W-1:0]  ch_int  [NUM_CH];
  logic [FRAC_W-1:0] ch_frac [NUM_CH];
  logic [QOS_W-1:0]  ch_qos  [NUM_CH];
  logic [CNT_W-1:0]  cnt_q   [NUM_CH];

  assign ch_valid  = {aw_valid, ar_valid};
  assign ch_nodata = {aw_nodata, ar_nodata};
  assign ch_rdy_dn = {aw_ready_dn, ar_ready_dn};
  assign ch_done   = {b_valid & b_ready & b_regcls,
                      r_valid & r_ready & r_last & r_regcls};
  assign ch_int[CH_RD]  = rd_lim_int;
  assign ch_int[CH_WR]  = wr_lim_int;
  assign ch_frac[CH_RD] = rd_lim_frac;
  assign ch_frac[CH_WR] = wr_lim_frac;
  assign ch_qos[CH_RD]  = ar_qos;
  assign ch_qos[CH_WR]  = aw_qos;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ot_chan_gate #(.CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .QOS_W(QOS_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .en(reg_en),
      .lim_int(ch_int[c]), .lim_frac(ch_frac[c]),
      .a_valid(ch_valid[c]), .a_qos(ch_qos[c]), .a_nodata(ch_nodata[c]),
      .a_ready_dn(ch_rdy_dn[c]), .a_valid_dn(ch_valid_dn[c]),
      .a_ready_up(ch_rdy_up[c]), .done(ch_done[c]), .cnt(cnt_q[c])
    );
  end

  assign ar_ready    = ch_rdy_up[CH_RD];
  assign ar_valid_dn = ch_valid_dn[CH_RD];
  assign aw_ready    = ch_rdy_up[CH_WR];
  assign aw_valid_dn = ch_valid_dn[CH_WR];
endmodule

// File: rtl/ot_regulator_chk.sv
module ot_regulator_chk #(
  parameter int CNT_W  = 6,
  parameter int INT_W  = 4,
  parameter int FRAC_W = 8,
  parameter int QOS_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_en,
  input logic [INT_W-1:0]  rd_lim_int,
  input logic [FRAC_W-1:0] rd_lim_frac,
  input logic [INT_W-1:0]  wr_lim_int,
  input logic [FRAC_W-1:0] wr_lim_frac,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [QOS_W-1:0]  ar_qos,
  input logic              ar_nodata,
  input logic              ar_valid_dn,
  input logic              ar_ready_dn,
  input logic              rd_done,
  input logic              aw_valid,
  input logic              aw_ready,
  input logic [QOS_W-1:0]  aw_qos,
  input logic              aw_nodata,
  input logic [CNT_W-1:0]  rd_cnt,
  input logic [CNT_W-1:0]  wr_cnt
);
  logic rd_reg, rd_hs, wr_hs;
  assign rd_reg = (ar_qos == '0) && !ar_nodata;
  assign rd_hs  = ar_valid && ar_ready && rd_reg;
  assign wr_hs  = aw_valid && aw_ready && (aw_qos == '0) && !aw_nodata;

  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hs && !rd_done && rd_cnt != {CNT_W{1'b1}} |=> rd_cnt == $past(rd_cnt) + 1'b1);

  p_cap_zero_frac_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && rd_lim_frac == '0 && rd_hs |-> rd_cnt < CNT_W'(rd_lim_int));

  p_cap_frac_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && rd_lim_frac != '0 && rd_hs |-> rd_cnt <= CNT_W'(rd_lim_int));

  p_qos_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ar_qos != '0 |-> ar_ready == ar_ready_dn && ar_valid_dn == ar_valid);

  p_nodata_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ar_nodata |-> ar_ready == ar_ready_dn && ar_valid_dn == ar_valid);

  p_disabled_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |-> ar_ready == ar_ready_dn && ar_valid_dn == ar_valid);

  p_joint_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && rd_reg && !ar_valid_dn |-> !ar_ready);

  p_wr_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && wr_lim_frac == '0 && wr_hs |-> wr_cnt < CNT_W'(wr_lim_int));
endmodule

bind ot_regulator ot_regulator_chk #(
  .CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .QOS_W(QOS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en),
  .rd_lim_int(rd_lim_int), .rd_lim_frac(rd_lim_frac),
  .wr_lim_int(wr_lim_int), .wr_lim_frac(wr_lim_frac),
  .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_qos(ar_qos), .ar_nodata(ar_nodata),
  .ar_valid_dn(ar_valid_dn), .ar_ready_dn(ar_ready_dn),
  .rd_done(r_valid & r_ready & r_last & r_regcls),
  .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_qos(aw_qos), .aw_nodata(aw_nodata),
  .rd_cnt(cnt_q[0]), .wr_cnt(cnt_q[1])
);

// File: tb/ot_regulator_tb.sv
module ot_regulator_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_en;
  logic [3:0] rd_lim_int, wr_lim_int;
  logic [7:0] rd_lim_frac, wr_lim_frac;
  logic ar_valid, ar_ready, ar_nodata, ar_valid_dn, ar_ready_dn;
  logic [3:0] ar_qos, aw_qos;
  logic r_valid, r_ready, r_last, r_regcls;
  logic aw_valid, aw_ready, aw_nodata, aw_valid_dn, aw_ready_dn;
  logic b_valid, b_ready, b_regcls;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ot_regulator dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en),
    .rd_lim_int(rd_lim_int), .rd_lim_frac(rd_lim_frac),
    .wr_lim_int(wr_lim_int), .wr_lim_frac(wr_lim_frac),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_qos(ar_qos), .ar_nodata(ar_nodata),
    .ar_valid_dn(ar_valid_dn), .ar_ready_dn(ar_ready_dn),
    .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last), .r_regcls(r_regcls),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_qos(aw_qos), .aw_nodata(aw_nodata),
    .aw_valid_dn(aw_valid_dn), .aw_ready_dn(aw_ready_dn),
    .b_valid(b_valid), .b_ready(b_ready), .b_regcls(b_regcls)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_issue(input int n);
    for (int i = 0; i < n; i++) begin
      ar_valid = 1'b1;
      @(negedge clk);
    end
    ar_valid = 1'b0;
  endtask

  task automatic rd_finish(input logic last, input logic cls);
    r_valid = 1'b1; r_ready = 1'b1; r_last = last; r_regcls = cls;
    @(negedge clk);
    r_valid = 1'b0; r_ready = 1'b0; r_last = 1'b0; r_regcls = 1'b0;
  endtask

  task automatic set_rd(input logic [3:0] ip, input logic [7:0] fp);
    rd_lim_int = ip; rd_lim_frac = fp;
  endtask

  task automatic t_reset();
    set_rd(4'd1, 8'h00);
    ar_valid = 1'b1;
    #1;
    check("R1 ready after reset", ar_ready, 1'b1);
    check("R1 valid passes after reset", ar_valid_dn, 1'b1);
    ar_valid = 1'b0;
  endtask

  task automatic t_zero_frac();
    set_rd(4'd2, 8'h00);
    idle(5);
    rd_issue(2);
    ar_valid = 1'b1; #1;
    check("R3 stall at integer cap", ar_ready, 1'b0);
    check("R9 valid held while stalled", ar_valid_dn, 1'b0);
    ar_valid = 1'b0;
    rd_finish(1'b0, 1'b1);
    check("R2 non-last beat keeps count", ar_ready, 1'b0);
    rd_finish(1'b1, 1'b0);
    check("R2 unregulated-class completion keeps count", ar_ready, 1'b0);
    rd_finish(1'b1, 1'b1);
    check("R2 last beat releases one", ar_ready, 1'b1);
    rd_finish(1'b1, 1'b1);
  endtask

  task automatic t_frac_cap();
    set_rd(4'd1, 8'h80);
    idle(300);
    rd_issue(1);
    check("R4 second issue at integer with credit", ar_ready, 1'b1);
    rd_issue(1);
    check("R4 stall at integer plus one", ar_ready, 1'b0);
    idle(300);
    check("R4 still stalled after long wait", ar_ready, 1'b0);
    rd_finish(1'b1, 1'b1);
    rd_finish(1'b1, 1'b1);
    set_rd(4'd1, 8'h00);
    idle(300);
  endtask

  task automatic t_worked();
    set_rd(4'd0, 8'h80);
    idle(300);
    check("R5 issue with full credit", ar_ready, 1'b1);
    ar_valid = 1'b1;
    @(negedge clk);
    ar_valid = 1'b0;
    for (int k = 1; k <= 98; k++) begin
      @(negedge clk);
      if (k == 30) check("R5 stalled while in flight", ar_ready, 1'b0);
      if (k == 60) check("R5 stalled after completion", ar_ready, 1'b0);
      if (k == 97) check("R5 stalled at edge 97", ar_ready, 1'b0);
      if (k == 98) check("R5 released at edge 98", ar_ready, 1'b1);
      if (k == 49) begin
        r_valid = 1'b1; r_ready = 1'b1; r_last = 1'b1; r_regcls = 1'b1;
      end
      if (k == 50) begin
        r_valid = 1'b0; r_ready = 1'b0; r_last = 1'b0; r_regcls = 1'b0;
      end
    end
  endtask

  task automatic t_qos();
    set_rd(4'd0, 8'h00);
    idle(2);
    ar_valid = 1'b1; #1;
    check("R6 zero-QoS blocked at zero limit", ar_ready, 1'b0);
    ar_qos = 4'd3; #1;
    check("R6 nonzero QoS ready", ar_ready, 1'b1);
    check("R6 nonzero QoS valid passes", ar_valid_dn, 1'b1);
    idle(3);
    ar_valid = 1'b0; ar_qos = 4'd0;
    set_rd(4'd1, 8'h00); #1;
    check("R6 nonzero QoS not counted", ar_ready, 1'b1);
  endtask

  task automatic t_nodata();
    set_rd(4'd0, 8'h00);
    ar_nodata = 1'b1; ar_valid = 1'b1; #1;
    check("R7 dataless request passes", ar_ready, 1'b1);
    idle(3);
    ar_valid = 1'b0; ar_nodata = 1'b0;
    set_rd(4'd1, 8'h00); #1;
    check("R7 dataless request not counted", ar_ready, 1'b1);
  endtask

  task automatic t_disabled();
    reg_en = 1'b0;
    set_rd(4'd0, 8'h00); #1;
    check("R8 disabled passes", ar_ready, 1'b1);
    rd_issue(2);
    reg_en = 1'b1;
    set_rd(4'd2, 8'h00); #1;
    check("R8 count kept while disabled", ar_ready, 1'b0);
    rd_finish(1'b1, 1'b1);
    rd_finish(1'b1, 1'b1);
    check("R8 drained after enable", ar_ready, 1'b1);
  endtask

  task automatic t_write();
    set_rd(4'd1, 8'h00);
    wr_lim_int = 4'd1; wr_lim_frac = 8'h00;
    aw_valid = 1'b1;
    @(negedge clk);
    aw_valid = 1'b1; #1;
    check("R10 write capped", aw_ready, 1'b0);
    check("R10 write valid held", aw_valid_dn, 1'b0);
    check("R10 read unaffected", ar_ready, 1'b1);
    aw_valid = 1'b0;
    b_valid = 1'b1; b_ready = 1'b1; b_regcls = 1'b1;
    @(negedge clk);
    b_valid = 1'b0; b_ready = 1'b0; b_regcls = 1'b0;
    check("R10 write response releases", aw_ready, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; reg_en = 1'b1;
    rd_lim_int = 4'd1; rd_lim_frac = 8'h00;
    wr_lim_int = 4'd1; wr_lim_frac = 8'h00;
    ar_valid = 1'b0; ar_qos = 4'd0; ar_nodata = 1'b0; ar_ready_dn = 1'b1;
    r_valid = 1'b0; r_ready = 1'b0; r_last = 1'b0; r_regcls = 1'b0;
    aw_valid = 1'b0; aw_qos = 4'd0; aw_nodata = 1'b0; aw_ready_dn = 1'b1;
    b_valid = 1'b0; b_ready = 1'b0; b_regcls = 1'b0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_frac();
    t_frac_cap();
    t_worked();
    t_qos();
    t_nodata();
    t_disabled();
    t_write();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule